// File: doc/BRIEF.md
# Burst Address Counter with Mirror Register

This block produces the address that one memory port accesses in each clock cycle. At every rising clock edge it takes one of four actions. It can take an external start address, step the current address up by one, keep the current address, or go back to the start address it saved in a side register called the mirror. A port controller uses it for bursts. It sets a start address once, then steps or holds the counter one beat at a time. It can go back to the start of the burst whenever it likes without sending the address again.

The counter takes no account of read/write direction, chip selection or byte enables. Those controls are not inputs here. A snooze input freezes all counter state, as if the counter clock were stopped. The address and mirror registers have no power-up value. A two-state machine records whether any start address has been taken since reset.

- `ST_UNPRIMED`: no start address has been taken since reset. Both address outputs are driven as unknown (X) and `primed` is 0.
- `ST_PRIMED`: at least one start address has been taken. Both outputs show the register contents and `primed` is 1.
- Transition `T_PRIME` (`ST_UNPRIMED` to `ST_PRIMED`): a non-snoozed edge at which the load strobe is low and repeat is high.
- Transition `T_STAY`: every other edge leaves the state as it is. `ST_PRIMED` is left only by reset.

The four counter actions are selected by active-low controls, highest priority first:

| Priority | Controls at the edge | Action |
|---|---|---|
| 1 | `repeat_n` = 0 | address becomes the mirror contents |
| 2 | `load_n` = 0 | address and mirror both take `ext_addr` |
| 3 | `inc_n` = 0 | address becomes address + 1 |
| 4 | none low | address is held |

Top module: `burst_addr_counter`

## Requirements
- R1: At a rising edge with `snooze`=0, `load_n`=0 and `repeat_n`=1, both `acc_addr` and `mirror_addr` take the value `ext_addr` had at that edge.
- R2: At a rising edge with `snooze`=0, `load_n`=1, `inc_n`=0 and `repeat_n`=1, `acc_addr` becomes its previous value plus one, modulo 2^AW. All ones wraps to zero.
- R3: At a rising edge with `snooze`=0 and `load_n`, `inc_n` and `repeat_n` all 1, `acc_addr` keeps its value.
- R4: At a rising edge with `snooze`=0 and `repeat_n`=0, `acc_addr` becomes the mirror contents held before that edge. This applies whatever `load_n`, `inc_n` and `ext_addr` are.
- R5: While `load_n`=0, the level of `inc_n` has no effect on `acc_addr` or `mirror_addr`.
- R6: At a rising edge with `snooze`=1, `acc_addr`, `mirror_addr` and `primed` keep their values, whatever the other controls are.
- R7: `mirror_addr` changes only under the R1 condition. Increment, hold and repeat edges leave it unchanged.
- R8: After reset `primed` is 0, and it stays 0 until the first edge that meets the R1 condition. It then becomes 1 and stays 1 until the next reset. While `primed` is 0 the address outputs carry no defined value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the priming state only |
| snooze | input | 1 | High freezes all counter state |
| load_n | input | 1 | Active-low start-address strobe |
| inc_n | input | 1 | Active-low increment |
| repeat_n | input | 1 | Active-low return to mirror contents |
| ext_addr | input | AW | External start address |
| acc_addr | output | AW | Address accessed this cycle |
| mirror_addr | output | AW | Last loaded start address |
| primed | output | 1 | High once a start address has been taken since reset |

## Verification
The bench uses a 4-bit counter. It goes through all 16 combinations of snooze, load, increment and repeat, starting from every mirror value and from several distances between the counter and the mirror. This is where a wrong priority shows up. A design that lets load beat repeat would show the external address instead of the mirror. A design that also writes the mirror on a load-plus-repeat edge would return to the wrong start address later. A design that listens to increment during a load would show the address one too high.

The bench loads the all-ones address and then increments, to catch a counter that saturates or widens instead of wrapping to zero. Snooze is tested with every other control active, which catches a design that gates only some of its registers. Before any load, the bench applies increment, repeat and snoozed loads. A design that primes on the wrong condition raises `primed` too early.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_INC    = 2'd1,
        OP_HOLD   = 2'd2,
        OP_REPEAT = 2'd3
    } ctr_op_e;

    typedef enum logic {
        ST_UNPRIMED = 1'b0,
        ST_PRIMED   = 1'b1
    } prime_state_e;

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
    import burst_ctr_pkg::*;
(
    input  logic    load_n,
    input  logic    inc_n,
    input  logic    repeat_n,
    output ctr_op_e op
);

    // Repeat outranks load, and load outranks increment.
    always_comb begin
        if (!repeat_n)
            op = OP_REPEAT;
        else if (!load_n)
            op = OP_LOAD;
        else if (!inc_n)
            op = OP_INC;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_ctr_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          en,
    input  ctr_op_e       op,
    input  logic [AW-1:0] ext_addr,
    input  logic [AW-1:0] mirror_q,
    output logic [AW-1:0] addr_q
);

    localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] addr_d;

    always_comb begin
        unique case (op)
            OP_LOAD:   addr_d = ext_addr;
            OP_INC:    addr_d = addr_q + STEP;
            OP_HOLD:   addr_d = addr_q;
            OP_REPEAT: addr_d = mirror_q;
            default:   addr_d = addr_q;
        endcase
    end

    // No reset: the register has no power-up value.
    always_ff @(posedge clk) begin
        if (en)
            addr_q <= addr_d;
    end

endmodule

// File: rtl/burst_mirror_reg.sv
module burst_mirror_reg #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          capture,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] mirror_q
);

    // No reset: the register has no power-up value.
    always_ff @(posedge clk) begin
        if (capture)
            mirror_q <= ext_addr;
    end

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
    import burst_ctr_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snooze,
    input  logic          load_n,
    input  logic          inc_n,
    input  logic          repeat_n,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] mirror_addr,
    output logic          primed
);

    localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

    ctr_op_e       op;
    logic          run;
    logic          take_start;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] mirror_q;
    prime_state_e  state_q;
    prime_state_e  state_d;

    // The snooze input stands in for the stopped counter clock.
    assign run        = !snooze;
    assign take_start = run && (op == OP_LOAD);

    burst_op_decode u_decode (
        .load_n   (load_n),
        .inc_n    (inc_n),
        .repeat_n (repeat_n),
        .op       (op)
    );

    burst_addr_reg #(.AW(AW)) u_addr (
        .clk      (clk),
        .en       (run),
        .op       (op),
        .ext_addr (ext_addr),
        .mirror_q (mirror_q),
        .addr_q   (addr_q)
    );

    burst_mirror_reg #(.AW(AW)) u_mirror (
        .clk      (clk),
        .capture  (take_start),
        .ext_addr (ext_addr),
        .mirror_q (mirror_q)
    );

    // Next state: T_PRIME on the first start address, T_STAY otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNPRIMED: if (take_start) state_d = ST_PRIMED;
            ST_PRIMED:   state_d = ST_PRIMED;
            default:     state_d = ST_UNPRIMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_UNPRIMED;
        else
            state_q <= state_d;
    end

    // Outputs: nothing defined before the first start address.
    always_comb begin
        unique case (state_q)
            ST_PRIMED: begin
                acc_addr    = addr_q;
                mirror_addr = mirror_q;
                primed      = 1'b1;
            end
            default: begin
                acc_addr    = 'x;
                mirror_addr = 'x;
                primed      = 1'b0;
            end
        endcase
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && !load_n && repeat_n)
        |=> (acc_addr == $past(ext_addr)) && (mirror_addr == $past(ext_addr)));

    assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !snooze && load_n && !inc_n && repeat_n)
        |=> acc_addr == $past(acc_addr) + STEP);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !snooze && load_n && inc_n && repeat_n)
        |=> $stable(acc_addr));

    assert_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !snooze && !repeat_n)
        |=> acc_addr == $past(mirror_addr));

    assert_snooze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && snooze)
        |=> $stable(acc_addr) && $stable(mirror_addr) && primed);

    assert_mirror_only_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !(!snooze && !load_n && repeat_n))
        |=> $stable(mirror_addr));

    assert_prime_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!primed && !(!snooze && !load_n && repeat_n))
        |=> !primed);

endmodule

// File: tb/tb_burst_addr_counter.sv
module tb_burst_addr_counter;

    localparam int AW       = 4;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snooze = 1'b0;
    logic          load_n = 1'b1;
    logic          inc_n = 1'b1;
    logic          repeat_n = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] mirror_addr;
    logic          primed;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    int exp_acc = 0;
    int exp_mir = 0;
    bit exp_primed = 1'b0;

    burst_addr_counter #(.AW(AW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .snooze      (snooze),
        .load_n      (load_n),
        .inc_n       (inc_n),
        .repeat_n    (repeat_n),
        .ext_addr    (ext_addr),
        .acc_addr    (acc_addr),
        .mirror_addr (mirror_addr),
        .primed      (primed)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(string req, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // One clock: drive on the falling edge, model the rising edge, sample at the next falling edge.
    task automatic step(bit sn, bit ld, bit ic, bit rp, int ext);
        string tag_a;
        string tag_m;
        snooze   = sn;
        load_n   = ld;
        inc_n    = ic;
        repeat_n = rp;
        ext_addr = AW'(ext);
        @(posedge clk);
        tag_m = "R7";
        if (sn) begin
            tag_a = "R6"; tag_m = "R6";
        end else if (!rp) begin
            tag_a = "R4"; exp_acc = exp_mir;
        end else if (!ld) begin
            tag_a = ic ? "R1" : "R5"; tag_m = tag_a;
            exp_acc = ext; exp_mir = ext; exp_primed = 1'b1;
        end else if (!ic) begin
            tag_a = "R2"; exp_acc = (exp_acc + 1) % (1 << AW);
        end else begin
            tag_a = "R3";
        end
        @(negedge clk);
        check("R8", int'(primed), int'(exp_primed));
        if (exp_primed) begin
            check(tag_a, int'(acc_addr), exp_acc);
            check(tag_m, int'(mirror_addr), exp_mir);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8", int'(primed), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", int'(primed), 0);

        // R8: nothing but an active load may prime the counter.
        step(0, 1, 0, 1, 5);
        step(0, 1, 1, 0, 6);
        step(0, 0, 1, 0, 7);
        step(1, 0, 1, 1, 8);
        step(0, 1, 1, 1, 9);

        // R2: the all-ones address wraps to zero.
        step(0, 0, 1, 1, (1 << AW) - 1);
        step(0, 1, 0, 1, 0);
        check("R2", int'(acc_addr), 0);
        step(0, 1, 0, 1, 0);

        // Sweep: every mirror value, several offsets, all 16 control codes.
        for (int m = 0; m < (1 << AW); m++) begin
            for (int k = 0; k < 4; k++) begin
                for (int c = 0; c < 16; c++) begin
                    step(0, 0, 1, 1, m);
                    for (int i = 0; i < k; i++)
                        step(0, 1, 0, 1, (m + 9) % (1 << AW));
                    step(c[3], c[2], c[1], c[0], (m * 7 + k + c + 1) % (1 << AW));
                    step(0, 1, 1, 0, (m + 3) % (1 << AW));
                end
            end
        end

        // R8: reset drops the priming state again.
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", int'(primed), 0);
        rst_n = 1'b1;
        exp_primed = 1'b0;
        step(0, 1, 0, 0, 2);
        step(0, 0, 0, 1, 11);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule